// File: doc/BRIEF.md
# Short I/O Configuration Port Decoder

This block is the slave-side decoder for a 1 KB window placed in a 16-bit short I/O address space. Six switch inputs fix the window's position on a 1 KB boundary. A second switch sets the privilege rule: the port either answers supervisory accesses only, or answers both supervisory and non-privileged accesses. The privilege is read from the address modifier code that comes with each cycle.

Inside the window, each byte lane has its own job. The odd (low) byte lane goes to a 16-register real-time-clock port. The block gives that port a select, a register index, and a single read or write pulse for each access. The RTC registers repeat every 32 bytes across the whole window. The even (high) byte lane returns a read-only status byte that describes the device type and size fitted in each of two memory banks. Writes to that byte are acknowledged and then discarded. A data-acknowledge output closes each accepted cycle.

Top module: `sio_cfg_decoder`

## Requirements
- R1: The block responds only when address bits 15..10 equal `base_sw_i`. A switch input of 1 (switch open) matches an address bit of 1, and 0 (switch closed) matches 0.
- R2: The block accepts address modifier 6'h2D (supervisory short I/O) at all times. It accepts 6'h29 (non-privileged short I/O) only while `sup_only_i` is 0. Any other code gets no acknowledge, no select and no strobe.
- R3: `dtack_o` rises one clock after `as_i`, at least one data strobe, a window match and an accepted modifier are all present. It stays high while they are held. It falls in the same cycle that the strobes are released.
- R4: `rtc_idx_o` equals address bits 4..1. Register contents therefore repeat every 32 bytes across the window.
- R5: `rtc_sel_o` is high while an accepted cycle has the odd-byte strobe `ds_odd_i` asserted. A read produces one `rtc_rd_o` pulse and a write produces one `rtc_wr_o` pulse, each one cycle long and aligned with the rise of `dtack_o`.
- R6: On an accepted read with `ds_even_i` asserted, `data_o[15:8]` carries the status byte while `dtack_o` is high. The layout is bank 0 size in bits 9:8, bank 0 type in bits 11:10, bank 1 size in bits 13:12 and bank 1 type in bits 15:14.
- R7: A write to the even byte is acknowledged. It produces no `rtc_wr_o` pulse, and the status byte read afterwards is unchanged.
- R8: After reset, `dtack_o`, `rtc_rd_o`, `rtc_wr_o` and `data_o` are 0.
- R9: On an accepted read with `ds_odd_i` asserted, `data_o[7:0]` carries `rtc_rdata_i`. A byte lane that is not being read, and both lanes whenever `dtack_o` is low, read as 0.
- R10: Holding the strobes for extra cycles produces no further read or write pulse. A new pulse needs the strobes to be released first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_i | input | 1 | Address strobe, address and modifier valid |
| ds_odd_i | input | 1 | Odd (low, D7..D0) byte strobe |
| ds_even_i | input | 1 | Even (high, D15..D8) byte strobe |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| addr_i | input | 15 | Address bits 15..1 |
| am_i | input | 6 | Address modifier code |
| base_sw_i | input | 6 | Window base switches for address bits 15..10 |
| sup_only_i | input | 1 | 1 = answer supervisory accesses only |
| bank_type_i | input | 4 | Type code per bank, bank 0 in bits 1:0 |
| bank_size_i | input | 4 | Size code per bank, bank 0 in bits 1:0 |
| rtc_rdata_i | input | 8 | Read data from the RTC register port |
| rtc_sel_o | output | 1 | RTC port selected |
| rtc_idx_o | output | 4 | RTC register index |
| rtc_rd_o | output | 1 | One-cycle RTC read pulse |
| rtc_wr_o | output | 1 | One-cycle RTC write pulse |
| dtack_o | output | 1 | Data acknowledge |
| data_o | output | 16 | Read data, both byte lanes |

## Verification
The block holds only the acknowledge flag and the two pulse flags. A wrong value in any of them therefore shows at the ports within a single clock. If the acknowledge flag is stuck low, `dtack_o` never rises and both data lanes stay 0. If it is stuck high, every accepted access loses its read or write pulse. A pulse flag that fails to clear shows up as a second pulse on the next held-strobe cycle. A decode fault of the window or modifier shows up as an acknowledge for a cycle that should go unanswered, or no acknowledge for one that should be answered, one clock after the strobe.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the short I/O configuration port decoder.
// Assumes a six-bit address modifier field.
package sio_cfg_pkg;
    localparam logic [5:0] AM_SIO_SUP = 6'h2D;
    localparam logic [5:0] AM_SIO_USR = 6'h29;

    // Decoded view of the current bus cycle.
    typedef struct packed {
        logic hit;
        logic odd;
        logic even;
        logic wr;
    } sio_acc_t;
endpackage

// File: rtl/sio_win_match.sv
// Window and privilege decode. Compares the upper address bits with the
// base switches and filters the address modifier. Purely combinational.
// Assumes the switch inputs are already logic levels (open = 1).
module sio_win_match
    import sio_cfg_pkg::*;
#(
    parameter int BASE_W = 6
) (
    input  logic              as_i,
    input  logic              ds_odd_i,
    input  logic              ds_even_i,
    input  logic              write_i,
    input  logic [BASE_W-1:0] addr_hi_i,
    input  logic [5:0]        am_i,
    input  logic [BASE_W-1:0] base_sw_i,
    input  logic              sup_only_i,
    output sio_acc_t          acc_o
);
    logic win_ok;
    logic am_ok;

    // Compare window bits and accept modifier codes by privilege rule.
    always_comb begin
        win_ok     = (addr_hi_i == base_sw_i);
        am_ok      = (am_i == AM_SIO_SUP) || ((am_i == AM_SIO_USR) && !sup_only_i);
        acc_o.hit  = as_i && (ds_odd_i || ds_even_i) && win_ok && am_ok;
        acc_o.odd  = ds_odd_i;
        acc_o.even = ds_even_i;
        acc_o.wr   = write_i;
    end
endmodule

// File: rtl/sio_ack_ctrl.sv
// Acknowledge and strobe control. Registers the decode hit so that the
// acknowledge follows one clock later, and issues one RTC read or write
// pulse per access. Assumes the strobes are released between accesses.
module sio_ack_ctrl
    import sio_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sio_acc_t acc_i,
    output logic     dtack_o,
    output logic     rd_pulse_o,
    output logic     wr_pulse_o
);
    logic ack_q;
    logic rd_q;
    logic wr_q;
    logic first_w;

    // First cycle of an accepted access on the odd lane.
    always_comb first_w = acc_i.hit && !ack_q && acc_i.odd;

    // Track the acknowledge state and the single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            ack_q <= acc_i.hit;
            rd_q  <= first_w && !acc_i.wr;
            wr_q  <= first_w && acc_i.wr;
        end
    end

    // Release the acknowledge as soon as the cycle goes away.
    always_comb begin
        dtack_o    = ack_q && acc_i.hit;
        rd_pulse_o = rd_q;
        wr_pulse_o = wr_q;
    end
endmodule

// File: rtl/sio_status_mux.sv
// Read-data steering. Packs the per-bank type and size codes into the
// even-lane status byte and routes RTC read data to the odd lane. Lanes
// not being read drive zero. Assumes NUM_BANKS*(TYPE_W+SIZE_W) <= DATA_W/2.
module sio_status_mux
    import sio_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int TYPE_W    = 2,
    parameter int SIZE_W    = 2,
    parameter int DATA_W    = 16
) (
    input  logic [NUM_BANKS*TYPE_W-1:0] bank_type_i,
    input  logic [NUM_BANKS*SIZE_W-1:0] bank_size_i,
    input  logic [DATA_W/2-1:0]         rtc_rdata_i,
    input  logic                        dtack_i,
    input  sio_acc_t                    acc_i,
    output logic [DATA_W-1:0]           data_o
);
    localparam int LANE_W  = DATA_W / 2;
    localparam int FIELD_W = TYPE_W + SIZE_W;
    localparam int USED_W  = NUM_BANKS * FIELD_W;

    logic [LANE_W-1:0] status_w;
    logic              rd_ok;

    // One field per bank: size in the low bits, type above it.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign status_w[b*FIELD_W +: SIZE_W]          = bank_size_i[b*SIZE_W +: SIZE_W];
        assign status_w[b*FIELD_W + SIZE_W +: TYPE_W] = bank_type_i[b*TYPE_W +: TYPE_W];
    end

    // Spare status bits read as zero.
    if (USED_W < LANE_W) begin : g_pad
        assign status_w[LANE_W-1:USED_W] = '0;
    end

    // Drive each lane only during an acknowledged read of that lane.
    always_comb begin
        rd_ok  = dtack_i && !acc_i.wr;
        data_o = '0;
        if (rd_ok && acc_i.even) data_o[DATA_W-1:LANE_W] = status_w;
        if (rd_ok && acc_i.odd)  data_o[LANE_W-1:0]      = rtc_rdata_i;
    end
endmodule

// File: rtl/sio_cfg_decoder.sv
// Top level of the short I/O configuration port decoder. Decodes a
// 2**WIN_LOG2-byte window, gives the RTC register port its select, index
// and pulses, returns the bank status byte and acknowledges the cycle.
// Assumes synchronous bus inputs.
module sio_cfg_decoder
    import sio_cfg_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_LOG2  = 10,
    parameter int IDX_W     = 4,
    parameter int NUM_BANKS = 2,
    parameter int TYPE_W    = 2,
    parameter int SIZE_W    = 2,
    parameter int DATA_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          as_i,
    input  logic                          ds_odd_i,
    input  logic                          ds_even_i,
    input  logic                          write_i,
    input  logic [ADDR_W-1:1]             addr_i,
    input  logic [5:0]                    am_i,
    input  logic [ADDR_W-WIN_LOG2-1:0]    base_sw_i,
    input  logic                          sup_only_i,
    input  logic [NUM_BANKS*TYPE_W-1:0]   bank_type_i,
    input  logic [NUM_BANKS*SIZE_W-1:0]   bank_size_i,
    input  logic [DATA_W/2-1:0]           rtc_rdata_i,
    output logic                          rtc_sel_o,
    output logic [IDX_W-1:0]              rtc_idx_o,
    output logic                          rtc_rd_o,
    output logic                          rtc_wr_o,
    output logic                          dtack_o,
    output logic [DATA_W-1:0]             data_o
);
    localparam int BASE_W = ADDR_W - WIN_LOG2;

    sio_acc_t acc;

    sio_win_match #(.BASE_W(BASE_W)) u_match (
        .as_i       (as_i),
        .ds_odd_i   (ds_odd_i),
        .ds_even_i  (ds_even_i),
        .write_i    (write_i),
        .addr_hi_i  (addr_i[ADDR_W-1:WIN_LOG2]),
        .am_i       (am_i),
        .base_sw_i  (base_sw_i),
        .sup_only_i (sup_only_i),
        .acc_o      (acc)
    );

    sio_ack_ctrl u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (acc),
        .dtack_o    (dtack_o),
        .rd_pulse_o (rtc_rd_o),
        .wr_pulse_o (rtc_wr_o)
    );

    sio_status_mux #(
        .NUM_BANKS (NUM_BANKS),
        .TYPE_W    (TYPE_W),
        .SIZE_W    (SIZE_W),
        .DATA_W    (DATA_W)
    ) u_data (
        .bank_type_i (bank_type_i),
        .bank_size_i (bank_size_i),
        .rtc_rdata_i (rtc_rdata_i),
        .dtack_i     (dtack_o),
        .acc_i       (acc),
        .data_o      (data_o)
    );

    // RTC select and index; upper offset bits only repeat the registers.
    always_comb begin
        rtc_sel_o = acc.hit && acc.odd;
        rtc_idx_o = addr_i[IDX_W:1];
    end
endmodule

// File: rtl/sio_cfg_decoder_chk.sv
// Port-level protocol checker for sio_cfg_decoder, bound into every instance.
module sio_cfg_decoder_chk #(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 10,
    parameter int DATA_W   = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       as_i,
    input logic                       ds_odd_i,
    input logic                       ds_even_i,
    input logic                       write_i,
    input logic [ADDR_W-1:1]          addr_i,
    input logic [5:0]                 am_i,
    input logic [ADDR_W-WIN_LOG2-1:0] base_sw_i,
    input logic                       sup_only_i,
    input logic                       rtc_rd_o,
    input logic                       rtc_wr_o,
    input logic                       dtack_o,
    input logic [DATA_W-1:0]          data_o
);
    // R1: acknowledge only inside the selected window
    a_r1_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_o |-> (addr_i[ADDR_W-1:WIN_LOG2] == base_sw_i));

    // R2: acknowledge only for an accepted modifier
    a_r2_am_filter: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_o |-> ((am_i == 6'h2D) || ((am_i == 6'h29) && !sup_only_i)));

    // R3: acknowledge needs a live strobe and follows a strobe in the prior cycle
    a_r3_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_o |-> (as_i && (ds_odd_i || ds_even_i)));
    a_r3_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_o) |-> $past(as_i && (ds_odd_i || ds_even_i)));

    // R5 / R7: write pulse only after an odd-lane write
    a_r7_wr_odd_only: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_wr_o |-> $past(ds_odd_i && write_i));
    a_r5_rd_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_rd_o |-> $past(ds_odd_i && !write_i));

    // R10: pulses last one cycle
    a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_wr_o |=> !rtc_wr_o);
    a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_rd_o |=> !rtc_rd_o);

    // R9: lanes quiet without acknowledge
    a_r9_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_o |-> (data_o == '0));
endmodule

bind sio_cfg_decoder sio_cfg_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_i       (as_i),
    .ds_odd_i   (ds_odd_i),
    .ds_even_i  (ds_even_i),
    .write_i    (write_i),
    .addr_i     (addr_i),
    .am_i       (am_i),
    .base_sw_i  (base_sw_i),
    .sup_only_i (sup_only_i),
    .rtc_rd_o   (rtc_rd_o),
    .rtc_wr_o   (rtc_wr_o),
    .dtack_o    (dtack_o),
    .data_o     (data_o)
);

// File: tb/sio_cfg_decoder_bench.sv
// Scoreboard bench: the driver task predicts each access and queues the
// prediction; the monitor pops and compares at the acknowledge cycle.
module sio_cfg_decoder_bench;
    typedef struct packed {
        logic        ack;
        logic        sel;
        logic        rd;
        logic        wr;
        logic [3:0]  idx;
        logic [15:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_i = 1'b0, ds_odd_i = 1'b0, ds_even_i = 1'b0, write_i = 1'b0;
    logic [15:1] addr_i = '0;
    logic [5:0]  am_i = '0;
    logic [5:0]  base_sw_i = 6'b110100;
    logic        sup_only_i = 1'b1;
    logic [3:0]  bank_type_i = 4'b1001;
    logic [3:0]  bank_size_i = 4'b0111;
    logic [7:0]  rtc_rdata_i = 8'hC3;
    logic        rtc_sel_o, rtc_rd_o, rtc_wr_o, dtack_o;
    logic [3:0]  rtc_idx_o;
    logic [15:0] data_o;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t exp_q[$];
    string tag_q[$];
    event obs_ev;

    always #10 clk = ~clk;

    sio_cfg_decoder u_sio_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_odd_i(ds_odd_i),
        .ds_even_i(ds_even_i), .write_i(write_i), .addr_i(addr_i), .am_i(am_i),
        .base_sw_i(base_sw_i), .sup_only_i(sup_only_i), .bank_type_i(bank_type_i),
        .bank_size_i(bank_size_i), .rtc_rdata_i(rtc_rdata_i), .rtc_sel_o(rtc_sel_o),
        .rtc_idx_o(rtc_idx_o), .rtc_rd_o(rtc_rd_o), .rtc_wr_o(rtc_wr_o),
        .dtack_o(dtack_o), .data_o(data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model of the requirements for one access.
    function automatic exp_t predict(input logic [15:0] a, input logic [5:0] am,
                                     input logic odd, input logic even, input logic wr);
        exp_t e;
        logic hit;
        logic [7:0] status;
        hit = (a[15:10] == base_sw_i) && (odd || even) &&
              ((am == 6'h2D) || ((am == 6'h29) && !sup_only_i));
        status = {bank_type_i[3:2], bank_size_i[3:2], bank_type_i[1:0], bank_size_i[1:0]};
        e.ack  = hit;
        e.sel  = hit && odd;
        e.rd   = hit && odd && !wr;
        e.wr   = hit && odd && wr;
        e.idx  = a[4:1];
        e.data = {(hit && !wr && even) ? status : 8'h00,
                  (hit && !wr && odd)  ? rtc_rdata_i : 8'h00};
        return e;
    endfunction

    // Driver: one access, prediction queued, then hold and release checks.
    task automatic access(input logic [15:0] a, input logic [5:0] am, input logic odd,
                          input logic even, input logic wr, input string tag);
        exp_t e;
        @(negedge clk);
        addr_i = a[15:1]; am_i = am; write_i = wr;
        as_i = 1'b1; ds_odd_i = odd; ds_even_i = even;
        e = predict(a, am, odd, even, wr);
        @(posedge clk);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> obs_ev;
        @(negedge clk);
        chk({tag, " R10 held ack"}, {31'd0, dtack_o}, {31'd0, e.ack});
        chk({tag, " R10 no repeat pulse"}, {30'd0, rtc_rd_o, rtc_wr_o}, 32'd0);
        as_i = 1'b0; ds_odd_i = 1'b0; ds_even_i = 1'b0;
        #1;
        chk({tag, " R3 release"}, {31'd0, dtack_o}, 32'd0);
        @(negedge clk);
    endtask

    // Monitor: compare the acknowledge-cycle outputs against the queue.
    always begin
        exp_t e;
        string t;
        @(obs_ev);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " R3 dtack"}, {31'd0, dtack_o}, {31'd0, e.ack});
        chk({t, " R5 sel"}, {31'd0, rtc_sel_o}, {31'd0, e.sel});
        chk({t, " R5 rd/wr pulse"}, {30'd0, rtc_rd_o, rtc_wr_o}, {30'd0, e.rd, e.wr});
        if (e.sel) chk({t, " R4 index"}, {28'd0, rtc_idx_o}, {28'd0, e.idx});
        chk({t, " R6/R9 data"}, {16'd0, data_o}, {16'd0, e.data});
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset dtack", {31'd0, dtack_o}, 32'd0);
        chk("R8 reset pulses", {30'd0, rtc_rd_o, rtc_wr_o}, 32'd0);
        chk("R8 reset data", {16'd0, data_o}, 32'd0);
        rst_n = 1'b1;
        // base 110100 -> window 0xD000
        access(16'hD005, 6'h2D, 1'b1, 1'b0, 1'b0, "R5 odd read idx2");
        access(16'hD01F, 6'h2D, 1'b1, 1'b0, 1'b1, "R5 odd write idx15");
        access(16'hD3E7, 6'h2D, 1'b1, 1'b0, 1'b0, "R4 shadow idx3");
        access(16'hD027, 6'h2D, 1'b1, 1'b0, 1'b0, "R4 shadow idx3 low");
        access(16'hD101, 6'h29, 1'b1, 1'b0, 1'b0, "R2 user AM blocked");
        sup_only_i = 1'b0;
        access(16'hD101, 6'h29, 1'b1, 1'b0, 1'b0, "R2 user AM allowed");
        access(16'hD101, 6'h3D, 1'b1, 1'b0, 1'b0, "R2 foreign AM");
        access(16'hD501, 6'h2D, 1'b1, 1'b0, 1'b0, "R1 other window");
        access(16'hD200, 6'h2D, 1'b0, 1'b1, 1'b0, "R6 status read");
        bank_type_i = 4'b0110; bank_size_i = 4'b1100;
        access(16'hD3FE, 6'h2D, 1'b0, 1'b1, 1'b0, "R6 status read new");
        access(16'hD010, 6'h2D, 1'b0, 1'b1, 1'b1, "R7 status write");
        access(16'hD010, 6'h2D, 1'b0, 1'b1, 1'b0, "R7 status after write");
        rtc_rdata_i = 8'h3A;
        access(16'hD00C, 6'h29, 1'b1, 1'b1, 1'b0, "R9 word read");
        base_sw_i = 6'b101010;
        access(16'hD00C, 6'h2D, 1'b1, 1'b0, 1'b0, "R1 old base miss");
        access(16'hA80C, 6'h2D, 1'b1, 1'b0, 1'b0, "R1 new base hit");
        access(16'hA80E, 6'h2D, 1'b1, 1'b0, 1'b1, "R5 write new base");
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule